// File: doc/BRIEF.md
# Overcurrent and Thermal Alarm Monitor

This block watches three digitised quantities of a power stage: output current in milliamps, droop of the output below half the input voltage in millivolts, and die temperature in whole degrees Celsius. Each cycle it compares them against limits set by register codes. It produces a protection trip, two live status flags with hysteresis, and a bank of sticky interrupt bits. The conversion that produces the samples happens upstream.

The current limit and droop limit arrive as compact codes. Each code covers a linear range and also a few discrete extra settings, and the block decodes them itself. The high-current alarm and the thermal shutdown each use separate set and release levels, so a reading that sits near a threshold does not make them chatter. Percentage thresholds come from integer products compared side by side, so the block needs no divider. Software acknowledges an interrupt by pulsing the matching bit of a write-one-to-clear strobe.

Top module: `prot_monitor`

## Requirements
- R1: Current limit code c (5 bits) decodes to 4200 + 200*c mA for c = 0..27. Codes 28, 29, 30 and 31 decode to 10000, 10400, 11000 and 11600 mA. The trip sets when current >= limit.
- R2: Droop limit code d (4 bits) decodes to 110 + 10*d mV for d = 0..13, and code 14 decodes to 310 mV. The trip also sets when droop >= the droop limit.
- R3: Droop code 15 disables the droop check, so any droop value leaves the trip low when current is below its limit.
- R4: The high-current alarm condition is 100*current >= 90*limit when alm_pct_sel_i = 0, or 100*current >= 80*limit when alm_pct_sel_i = 1. The condition sets oc_alm_o and interrupt bit 0.
- R5: oc_alm_o clears when 100*current < 85*limit and the set condition is false. Otherwise it keeps its value.
- R6: tshdn_o sets, and interrupt bit 3 sets, when temperature > 155. tshdn_o clears when temperature <= 140 and holds between those two levels.
- R7: Interrupt bit 1 sets when temperature >= 100, and interrupt bit 2 sets when temperature >= 120.
- R8: Interrupt bits are sticky. A 1 on irq_clr_i[k] clears bit k, but a set condition in the same cycle wins.
- R9: While rst_ni is low, every output is 0.
- R10: Every output is registered: it reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iout_ma_i | input | IW | Output current sample, mA |
| droop_mv_i | input | VW | Droop of output below half input, mV |
| temp_c_i | input | TW | Die temperature, degrees C |
| ilim_code_i | input | 5 | Current limit code |
| vlim_code_i | input | 4 | Droop limit code (15 = off) |
| alm_pct_sel_i | input | 1 | Alarm set level: 0 = 90 %, 1 = 80 % |
| irq_clr_i | input | 4 | Write-one-to-clear strobe per interrupt bit |
| trip_o | output | 1 | Protection trip |
| oc_alm_o | output | 1 | High-current alarm status |
| tshdn_o | output | 1 | Thermal shutdown status |
| irq_o | output | 4 | Sticky interrupts: 0 high current, 1 100 C, 2 120 C, 3 shutdown |

## Verification
The hardest states to reach are the hysteresis bands. In those bands the status outputs depend on history and not on the present sample. Examples are a current between 85 % and the set level after the alarm has set, and a temperature between 141 and 155 degrees after a shutdown. Directed sequences walk into each band from both sides and step across every boundary value one unit at a time. They also cover the 80 % setting, where the set level lies below the clear level. Random stimulus then keeps the limit codes fixed for runs of cycles and moves current and temperature in small steps around the thresholds, so that those bands are entered and left many times.

// File: rtl/prot_mon_pkg.sv
package prot_mon_pkg;
  localparam int ILIM_CODE_W = 5;
  localparam int VLIM_CODE_W = 4;
  localparam int NUM_IRQ     = 4;

  // current limit decode
  localparam int ILIM_BASE_MA = 4200;
  localparam int ILIM_STEP_MA = 200;
  localparam logic [ILIM_CODE_W-1:0] ILIM_LIN_LAST = 5'd27;
  localparam int ILIM_XTRA_MA [4] = '{10000, 10400, 11000, 11600};

  // droop limit decode
  localparam int VLIM_BASE_MV = 110;
  localparam int VLIM_STEP_MV = 10;
  localparam logic [VLIM_CODE_W-1:0] VLIM_LIN_LAST = 4'd13;
  localparam logic [VLIM_CODE_W-1:0] VLIM_CODE_XTRA = 4'd14;
  localparam int VLIM_XTRA_MV = 310;

  // alarm percentages
  localparam int OC_SET_PCT_HI = 90;
  localparam int OC_SET_PCT_LO = 80;
  localparam int OC_CLR_PCT    = 85;

  // thermal levels, degrees C
  localparam int T_SHDN_C = 155;
  localparam int T_HYST_C = 15;
  localparam int T_ALM1_C = 100;
  localparam int T_ALM2_C = 120;

  typedef enum int {
    IRQ_OC   = 0,
    IRQ_ALM1 = 1,
    IRQ_ALM2 = 2,
    IRQ_SHDN = 3
  } irq_idx_e;
endpackage

// File: rtl/prot_limit_decode.sv
module prot_limit_decode
  import prot_mon_pkg::*;
#(
  parameter int IW = 14,
  parameter int VW = 10
) (
  input  logic [ILIM_CODE_W-1:0] ilim_code_i,
  input  logic [VLIM_CODE_W-1:0] vlim_code_i,
  output logic [IW-1:0]          ilim_ma_o,
  output logic [VW-1:0]          vlim_mv_o,
  output logic                   vlim_off_o
);

  always_comb begin
    if (ilim_code_i <= ILIM_LIN_LAST) begin
      ilim_ma_o = IW'(ILIM_BASE_MA) + IW'(ILIM_STEP_MA) * IW'(ilim_code_i);
    end else begin
      // extra codes sit at the top of the code space; low two bits index them
      ilim_ma_o = IW'(ILIM_XTRA_MA[ilim_code_i[1:0]]);
    end
  end

  always_comb begin
    vlim_off_o = 1'b0;
    if (vlim_code_i <= VLIM_LIN_LAST) begin
      vlim_mv_o = VW'(VLIM_BASE_MV) + VW'(VLIM_STEP_MV) * VW'(vlim_code_i);
    end else if (vlim_code_i == VLIM_CODE_XTRA) begin
      vlim_mv_o = VW'(VLIM_XTRA_MV);
    end else begin
      vlim_mv_o  = '0;
      vlim_off_o = 1'b1;
    end
  end

endmodule

// File: rtl/prot_oc_alarm.sv
module prot_oc_alarm
  import prot_mon_pkg::*;
#(
  parameter int IW = 14,
  parameter int VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] iout_ma_i,
  input  logic [VW-1:0] droop_mv_i,
  input  logic [IW-1:0] ilim_ma_i,
  input  logic [VW-1:0] vlim_mv_i,
  input  logic          vlim_off_i,
  input  logic          alm_pct_sel_i,
  output logic          trip_o,
  output logic          oc_alm_o,
  output logic          oc_set_o
);

  // 100*x fits in IW+7 bits
  localparam int PW = IW + 7;

  logic [PW-1:0] i_x100;
  logic [PW-1:0] set_ref;
  logic [PW-1:0] clr_ref;
  logic [6:0]    set_pct;
  logic          oc_clr;
  logic          trip_d;

  assign set_pct = alm_pct_sel_i ? 7'(OC_SET_PCT_LO) : 7'(OC_SET_PCT_HI);
  assign i_x100  = PW'(iout_ma_i) * PW'(100);
  assign set_ref = PW'(ilim_ma_i) * PW'(set_pct);
  assign clr_ref = PW'(ilim_ma_i) * PW'(OC_CLR_PCT);

  assign oc_set_o = (i_x100 >= set_ref);
  assign oc_clr   = (i_x100 <  clr_ref);

  assign trip_d = (iout_ma_i >= ilim_ma_i) ||
                  (!vlim_off_i && (droop_mv_i >= vlim_mv_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_o   <= 1'b0;
      oc_alm_o <= 1'b0;
    end else begin
      trip_o <= trip_d;
      // set has priority; 80 % set level lies below the clear level
      if (oc_set_o)    oc_alm_o <= 1'b1;
      else if (oc_clr) oc_alm_o <= 1'b0;
    end
  end

endmodule

// File: rtl/prot_thermal.sv
module prot_thermal
  import prot_mon_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] temp_c_i,
  output logic          tshdn_o,
  output logic          shdn_set_o,
  output logic          alm1_set_o,
  output logic          alm2_set_o
);

  localparam logic [TW-1:0] SHDN_LVL = TW'(T_SHDN_C);
  localparam logic [TW-1:0] REL_LVL  = TW'(T_SHDN_C - T_HYST_C);
  localparam logic [TW-1:0] ALM1_LVL = TW'(T_ALM1_C);
  localparam logic [TW-1:0] ALM2_LVL = TW'(T_ALM2_C);

  logic shdn_rel;

  assign shdn_set_o = (temp_c_i >  SHDN_LVL);
  assign shdn_rel   = (temp_c_i <= REL_LVL);
  assign alm1_set_o = (temp_c_i >= ALM1_LVL);
  assign alm2_set_o = (temp_c_i >= ALM2_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tshdn_o <= 1'b0;
    end else if (shdn_set_o) begin
      tshdn_o <= 1'b1;
    end else if (shdn_rel) begin
      tshdn_o <= 1'b0;
    end
  end

endmodule

// File: rtl/prot_irq_bank.sv
module prot_irq_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irq_o
);

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       irq_o[k] <= 1'b0;
      else if (set_i[k]) irq_o[k] <= 1'b1;
      else if (clr_i[k]) irq_o[k] <= 1'b0;
    end
  end

endmodule

// File: rtl/prot_monitor.sv
module prot_monitor
  import prot_mon_pkg::*;
#(
  parameter int IW = 14,
  parameter int VW = 10,
  parameter int TW = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IW-1:0]          iout_ma_i,
  input  logic [VW-1:0]          droop_mv_i,
  input  logic [TW-1:0]          temp_c_i,
  input  logic [ILIM_CODE_W-1:0] ilim_code_i,
  input  logic [VLIM_CODE_W-1:0] vlim_code_i,
  input  logic                   alm_pct_sel_i,
  input  logic [NUM_IRQ-1:0]     irq_clr_i,
  output logic                   trip_o,
  output logic                   oc_alm_o,
  output logic                   tshdn_o,
  output logic [NUM_IRQ-1:0]     irq_o
);

  logic [IW-1:0]      ilim_ma;
  logic [VW-1:0]      vlim_mv;
  logic               vlim_off;
  logic               oc_set;
  logic               shdn_set;
  logic               alm1_set;
  logic               alm2_set;
  logic [NUM_IRQ-1:0] irq_set;

  prot_limit_decode #(.IW(IW), .VW(VW)) u_dec (
    .ilim_code_i (ilim_code_i),
    .vlim_code_i (vlim_code_i),
    .ilim_ma_o   (ilim_ma),
    .vlim_mv_o   (vlim_mv),
    .vlim_off_o  (vlim_off)
  );

  prot_oc_alarm #(.IW(IW), .VW(VW)) u_oc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .iout_ma_i     (iout_ma_i),
    .droop_mv_i    (droop_mv_i),
    .ilim_ma_i     (ilim_ma),
    .vlim_mv_i     (vlim_mv),
    .vlim_off_i    (vlim_off),
    .alm_pct_sel_i (alm_pct_sel_i),
    .trip_o        (trip_o),
    .oc_alm_o      (oc_alm_o),
    .oc_set_o      (oc_set)
  );

  prot_thermal #(.TW(TW)) u_th (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .temp_c_i   (temp_c_i),
    .tshdn_o    (tshdn_o),
    .shdn_set_o (shdn_set),
    .alm1_set_o (alm1_set),
    .alm2_set_o (alm2_set)
  );

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_OC]   = oc_set;
    irq_set[IRQ_ALM1] = alm1_set;
    irq_set[IRQ_ALM2] = alm2_set;
    irq_set[IRQ_SHDN] = shdn_set;
  end

  prot_irq_bank #(.N(NUM_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/prot_monitor_chk.sv
module prot_monitor_chk #(
  parameter int IW = 14,
  parameter int VW = 10,
  parameter int TW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] iout_ma_i,
  input logic [VW-1:0] droop_mv_i,
  input logic [TW-1:0] temp_c_i,
  input logic [4:0]    ilim_code_i,
  input logic [3:0]    vlim_code_i,
  input logic          alm_pct_sel_i,
  input logic [3:0]    irq_clr_i,
  input logic          trip_o,
  input logic          oc_alm_o,
  input logic          tshdn_o,
  input logic [3:0]    irq_o
);

  p_trip_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iout_ma_i >= IW'(11600) |=> trip_o);

  p_droop_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vlim_code_i == 4'd15) && (iout_ma_i < IW'(4200)) |=> !trip_o);

  p_oc_rise_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oc_alm_o) |-> irq_o[0]);

  p_tshdn_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_c_i > TW'(155) |=> tshdn_o && irq_o[3]);

  p_tshdn_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tshdn_o && (temp_c_i > TW'(140)) |=> tshdn_o);

  p_alm1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_c_i >= TW'(100) |=> irq_o[1]);

  p_alm2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_c_i >= TW'(120) |=> irq_o[2]);

  for (genvar k = 0; k < 4; k++) begin : g_sticky
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] && !irq_clr_i[k] |=> irq_o[k]);
  end

  p_clr_alm1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i[1] && (temp_c_i < TW'(100)) |=> !irq_o[1]);

  always_comb begin
    if (!rst_ni) begin
      p_reset_r9: assert (!trip_o && !oc_alm_o && !tshdn_o && irq_o == 4'd0);
    end
  end

endmodule

bind prot_monitor prot_monitor_chk #(.IW(IW), .VW(VW), .TW(TW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .iout_ma_i     (iout_ma_i),
  .droop_mv_i    (droop_mv_i),
  .temp_c_i      (temp_c_i),
  .ilim_code_i   (ilim_code_i),
  .vlim_code_i   (vlim_code_i),
  .alm_pct_sel_i (alm_pct_sel_i),
  .irq_clr_i     (irq_clr_i),
  .trip_o        (trip_o),
  .oc_alm_o      (oc_alm_o),
  .tshdn_o       (tshdn_o),
  .irq_o         (irq_o)
);

// File: tb/prot_monitor_test.sv
`timescale 1ns/1ps
module prot_monitor_test;
  localparam int IW = 14;
  localparam int VW = 10;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] iout = '0;
  logic [VW-1:0] droop = '0;
  logic [TW-1:0] temp = '0;
  logic [4:0]    ic = '0;
  logic [3:0]    vc = 4'd15;
  logic          sel = 1'b0;
  logic [3:0]    clr = '0;
  logic          trip, oc, ts;
  logic [3:0]    irq;

  int checks = 0;
  int errors = 0;
  bit e_trip = 0, e_oc = 0, e_ts = 0;
  logic [3:0] e_int = '0;

  always #2 clk = ~clk;

  prot_monitor #(.IW(IW), .VW(VW), .TW(TW)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .iout_ma_i (iout), .droop_mv_i (droop),
    .temp_c_i (temp), .ilim_code_i (ic), .vlim_code_i (vc),
    .alm_pct_sel_i (sel), .irq_clr_i (clr), .trip_o (trip),
    .oc_alm_o (oc), .tshdn_o (ts), .irq_o (irq)
  );

  function automatic int ilim_f(int c);
    if (c < 28) return 4200 + 200 * c;
    case (c)
      28: return 10000;
      29: return 10400;
      30: return 11000;
      default: return 11600;
    endcase
  endfunction

  function automatic int vlim_f(int c);
    if (c < 14) return 110 + 10 * c;
    if (c == 14) return 310;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(trip === e_trip, "R1 R2", "trip", int'(trip), int'(e_trip));
    chk(oc === e_oc, "R4 R5", "oc_alm", int'(oc), int'(e_oc));
    chk(ts === e_ts, "R6", "tshdn", int'(ts), int'(e_ts));
    chk(irq === e_int, "R7 R8", "irq", int'(irq), int'(e_int));
  endtask

  task automatic step();
    int lim, vl;
    bit set_c, clr_c;
    @(posedge clk);
    lim   = ilim_f(int'(ic));
    vl    = vlim_f(int'(vc));
    set_c = 100 * int'(iout) >= (sel ? 80 : 90) * lim;
    clr_c = 100 * int'(iout) < 85 * lim;
    e_oc  = set_c ? 1'b1 : (clr_c ? 1'b0 : e_oc);
    e_trip = (int'(iout) >= lim) || (vl >= 0 && int'(droop) >= vl);
    e_ts  = (temp > 155) ? 1'b1 : ((temp <= 140) ? 1'b0 : e_ts);
    e_int = (e_int & ~clr) | {temp > 8'd155, temp >= 8'd120, temp >= 8'd100, set_c};
    #1;
    compare_all();
    clr = '0;
  endtask

  task automatic drive(int i, int d, int t, int c_i, int c_v, bit s);
    iout = IW'(i); droop = VW'(d); temp = TW'(t);
    ic = 5'(c_i); vc = 4'(c_v); sel = s;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    drive(16000, 1023, 200, 0, 0, 0);
    #7;
    // R9: reset holds outputs low even with every condition active
    chk(!trip && !oc && !ts && irq == 4'd0, "R9", "reset outputs", int'({trip, oc, ts, irq}), 0);
    drive(1000, 0, 25, 0, 15, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    step();

    // R10: output changes only after the edge
    drive(4200, 0, 25, 0, 15, 0);
    #0.5;
    chk(trip == 1'b0, "R10", "trip before edge", int'(trip), 0);
    step();
    chk(trip == 1'b1, "R10", "trip after edge", int'(trip), 1);

    // R1 boundaries
    drive(4199, 0, 25, 0, 15, 0);   step();
    drive(9599, 0, 25, 27, 15, 0);  step();
    drive(9600, 0, 25, 27, 15, 0);  step();
    drive(9999, 0, 25, 28, 15, 0);  step();
    drive(10000, 0, 25, 28, 15, 0); step();
    drive(10399, 0, 25, 29, 15, 0); step();
    drive(11000, 0, 25, 30, 15, 0); step();
    drive(11599, 0, 25, 31, 15, 0); step();
    chk(trip == 1'b0, "R1", "11599 at code 31", int'(trip), 0);
    drive(11600, 0, 25, 31, 15, 0); step();
    chk(trip == 1'b1, "R1", "11600 at code 31", int'(trip), 1);

    // R2 droop
    drive(0, 109, 25, 0, 0, 0);  step();
    drive(0, 110, 25, 0, 0, 0);  step();
    chk(trip == 1'b1, "R2", "droop 110 code 0", int'(trip), 1);
    drive(0, 239, 25, 0, 13, 0); step();
    drive(0, 240, 25, 0, 13, 0); step();
    drive(0, 309, 25, 0, 14, 0); step();
    chk(trip == 1'b0, "R2", "droop 309 code 14", int'(trip), 0);
    drive(0, 310, 25, 0, 14, 0); step();

    // R3 droop off
    drive(0, 1023, 25, 0, 15, 0); step();
    chk(trip == 1'b0, "R3", "droop check off", int'(trip), 0);

    // R4 / R5 alarm hysteresis at 90 %, limit 4200
    clr = 4'hf; drive(0, 0, 25, 0, 15, 0); step();
    drive(3779, 0, 25, 0, 15, 0); step();
    chk(oc == 1'b0, "R4", "3779 below 90%", int'(oc), 0);
    drive(3780, 0, 25, 0, 15, 0); step();
    chk(oc == 1'b1 && irq[0], "R4", "3780 sets", int'({oc, irq[0]}), 3);
    drive(3570, 0, 25, 0, 15, 0); step();
    chk(oc == 1'b1, "R5", "3570 holds", int'(oc), 1);
    drive(3569, 0, 25, 0, 15, 0); step();
    chk(oc == 1'b0, "R5", "3569 clears", int'(oc), 0);
    // 80 % setting
    clr = 4'h1; drive(3359, 0, 25, 0, 15, 1); step();
    drive(3360, 0, 25, 0, 15, 1); step();
    chk(oc == 1'b1, "R4", "80% set at 3360", int'(oc), 1);
    drive(3400, 0, 25, 0, 15, 1); step();
    drive(3359, 0, 25, 0, 15, 1); step();
    chk(oc == 1'b0, "R5", "80% clear at 3359", int'(oc), 0);

    // R6 thermal shutdown
    clr = 4'hf; drive(0, 0, 155, 0, 15, 0); step();
    chk(ts == 1'b0, "R6", "155 no shutdown", int'(ts), 0);
    drive(0, 0, 156, 0, 15, 0); step();
    chk(ts && irq[3], "R6", "156 shutdown", int'({ts, irq[3]}), 3);
    drive(0, 0, 141, 0, 15, 0); step();
    chk(ts == 1'b1, "R6", "141 holds", int'(ts), 1);
    drive(0, 0, 140, 0, 15, 0); step();
    chk(ts == 1'b0, "R6", "140 releases", int'(ts), 0);

    // R7 alarm levels
    clr = 4'hf; drive(0, 0, 99, 0, 15, 0); step();
    chk(irq[1] == 1'b0, "R7", "99 no alarm", int'(irq[1]), 0);
    drive(0, 0, 100, 0, 15, 0); step();
    drive(0, 0, 119, 0, 15, 0); step();
    chk(irq[2:1] == 2'b01, "R7", "119 alarm1 only", int'(irq[2:1]), 1);
    drive(0, 0, 120, 0, 15, 0); step();

    // R8 sticky, set beats clear
    clr = 4'hf; drive(0, 0, 25, 0, 15, 0); step();
    chk(irq == 4'd0, "R8", "all cleared", int'(irq), 0);
    clr = 4'h2; drive(0, 0, 130, 0, 15, 0); step();
    chk(irq[1] == 1'b1, "R8", "set wins over clear", int'(irq[1]), 1);
    drive(0, 0, 25, 0, 15, 0); step();
    chk(irq == 4'b0110, "R8", "sticky after cool", int'(irq), 6);
    clr = 4'h2; step();
    chk(irq == 4'b0100, "R8", "single bit clear", int'(irq), 4);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int lim, t;
      if (n % 16 == 0) begin
        ic  = 5'($urandom_range(0, 31));
        vc  = 4'($urandom_range(0, 15));
        sel = 1'($urandom_range(0, 1));
      end
      lim = ilim_f(int'(ic));
      iout = IW'((lim * int'($urandom_range(70, 105))) / 100);
      droop = VW'($urandom_range(0, 8) == 0 ? $urandom_range(100, 330) : $urandom_range(0, 100));
      t = int'(temp) + int'($urandom_range(0, 8)) - 4;
      if (t < 90 || t > 170) t = 90 + int'($urandom_range(0, 80));
      temp = TW'(t);
      clr = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule